// File: doc/BRIEF.md
# Fractional Baud Rate Generator

This block derives the sampling strobes of a serial link from a fixed system clock. A divisor count sets the length of one sub-period in clocks, and a 4-bit fraction index adds a correction in sixteenths of a clock. The correction is applied by dithering: each bit period adds the index to a 4-bit phase accumulator. A carry out of the accumulator stretches that bit period by one clock. Averaged over sixteen bit periods, the stretch adds exactly the index in clocks.

A build-time parameter selects one of two variants. The serial variant produces an oversample strobe whose period is (count + 1) clocks, and a bit tick on every sixteenth strobe. Its bit rate is therefore clock / (16 × (count + 1) + index/16). The infrared timebase variant decodes only the low four bits of the divisor. It produces one strobe and one tick per period of (count + 1) clocks plus the dithered fraction. In that variant a zero divisor is an illegal setting, which the block reports. Writing either register restarts the generator on a clean period.

Top module: `frac_baud_gen`

## Requirements
- R1: After reset the divisor and fraction are zero. The serial variant then strobes `samp_o` on every clock, and `tick_o` is low in the first clock. The infrared variant raises `cfg_err_o` and keeps both strobes low.
- R2: After a divisor write of D, the first `samp_o` falls D+1 clocks after the write edge. Later strobes repeat every D+1 clocks, except where R4 stretches a bit.
- R3: In the serial variant, `tick_o` is high together with the sixteenth `samp_o` of each bit. No bit period is shorter than 16×(D+1) clocks.
- R4: The fraction index is taken from `wdata_i[7:4]` on a fraction write. The accumulator adds the index at each bit end, and a carry delays the final strobe of that bit by one clock. Any sixteen consecutive bits therefore last exactly 16 × (base bit length) + index clocks.
- R5: A write to either register clears the sub-period counter, the sample index and the accumulator. The first tick after a write comes one unstretched bit later.
- R6: The infrared variant uses only `wdata_i[3:0]` as D. Both `tick_o` and `samp_o` pulse once per period, and the period is never shorter than two clocks.
- R7: The infrared variant drives `cfg_err_o` high while its D is zero. During that time both strobes stay low. The serial variant never raises `cfg_err_o`.
- R8: `tick_o` is a single-clock strobe. It is never high on two clocks in a row, and it is only high together with `samp_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_div_i | input | 1 | Load the divisor from `wdata_i` |
| wr_frac_i | input | 1 | Load the fraction index from `wdata_i[7:4]` |
| wdata_i | input | CNT_W | Write data |
| samp_o | output | 1 | Oversample or infrared period strobe |
| tick_o | output | 1 | Bit tick strobe |
| cfg_err_o | output | 1 | Illegal divisor setting (infrared variant) |

## Verification
The bench builds two instances with CNT_W = 8 that share one write bus. One instance is the serial variant (IR_MODE = 0) and the other is the infrared variant (IR_MODE = 1). Because the bus is shared, a single write exercises both decodings at once. A value such as 0x20 gives the serial instance a long sub-period while putting the infrared instance into its illegal zero-divisor state. With the small divisors of an 8-bit count, a whole sixteen-bit dither cycle completes in a few hundred clocks. The bench can therefore compare complete carry patterns, and their total stretch, against a behavioural model on every clock.

// File: rtl/frac_baud_gen.sv
module frac_baud_gen #(
  parameter int CNT_W   = 8,
  parameter bit IR_MODE = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_div_i,
  input  logic             wr_frac_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic             samp_o,
  output logic             tick_o,
  output logic             cfg_err_o
);
  logic [CNT_W-1:0] div_q, cnt_q, lim;
  logic [3:0]       frac_q, acc_q, sub_q;
  logic [4:0]       sum;
  logic             ext_q, bit_end, at_lim, hold, wr;

  generate
    if (IR_MODE) begin : g_ir
      assign lim       = {{(CNT_W-4){1'b0}}, div_q[3:0]};
      assign bit_end   = 1'b1;
      assign cfg_err_o = (div_q[3:0] == 4'd0);
    end else begin : g_uart
      assign lim       = div_q;
      assign bit_end   = (sub_q == 4'hf);
      assign cfg_err_o = 1'b0;
    end
  endgenerate

  assign wr     = wr_div_i | wr_frac_i;
  assign sum    = {1'b0, acc_q} + {1'b0, frac_q};
  assign at_lim = (cnt_q == lim);
  assign hold   = at_lim & bit_end & sum[4] & ~ext_q;
  assign samp_o = ~cfg_err_o & (ext_q | (at_lim & ~hold));
  assign tick_o = samp_o & bit_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      frac_q <= '0;
      cnt_q  <= '0;
      sub_q  <= '0;
      acc_q  <= '0;
      ext_q  <= 1'b0;
    end else if (wr) begin
      if (wr_div_i)  div_q  <= wdata_i;
      if (wr_frac_i) frac_q <= wdata_i[7:4];
      cnt_q <= '0;
      sub_q <= '0;
      acc_q <= '0;
      ext_q <= 1'b0;
    end else if (cfg_err_o) begin
      cnt_q <= '0;
      ext_q <= 1'b0;
    end else if (samp_o) begin
      cnt_q <= '0;
      ext_q <= 1'b0;
      sub_q <= sub_q + 4'd1;
      if (bit_end) acc_q <= sum[3:0];
    end else if (hold) begin
      ext_q <= 1'b1;
    end else begin
      cnt_q <= cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
    end
  end
endmodule

module frac_baud_gen_chk #(
  parameter bit IR_MODE = 1'b0
) (
  input logic clk,
  input logic rst_n,
  input logic wr_div_i,
  input logic wr_frac_i,
  input logic samp_o,
  input logic tick_o,
  input logic cfg_err_o
);
  // R8
  tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);
  // R8
  tick_with_samp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |-> samp_o);
  // R7
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err_o |-> (!samp_o && !tick_o));
  // R5
  restart_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_div_i || wr_frac_i) |=> !tick_o);
  // R6
  ir_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (IR_MODE && samp_o) |=> !samp_o);
  // R7
  uart_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !IR_MODE |-> !cfg_err_o);
endmodule

bind frac_baud_gen frac_baud_gen_chk #(.IR_MODE(IR_MODE)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_div_i(wr_div_i), .wr_frac_i(wr_frac_i),
  .samp_o(samp_o), .tick_o(tick_o), .cfg_err_o(cfg_err_o)
);

// File: tb/test_frac_baud_gen.sv
module test_frac_baud_gen;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_div = 1'b0, wr_frac = 1'b0;
  logic [7:0] wdata = '0;
  logic samp_u, tick_u, err_u, samp_i, tick_i, err_i;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  frac_baud_gen #(.CNT_W(8), .IR_MODE(1'b0)) i_frac_baud_gen (
    .clk(clk), .rst_n(rst_n), .wr_div_i(wr_div), .wr_frac_i(wr_frac),
    .wdata_i(wdata), .samp_o(samp_u), .tick_o(tick_u), .cfg_err_o(err_u));

  frac_baud_gen #(.CNT_W(8), .IR_MODE(1'b1)) i_frac_baud_gen_ir (
    .clk(clk), .rst_n(rst_n), .wr_div_i(wr_div), .wr_frac_i(wr_frac),
    .wdata_i(wdata), .samp_o(samp_i), .tick_o(tick_i), .cfg_err_o(err_i));

  int pos[2], acc[2], sidx[2], dd[2], kk[2];

  function automatic bit m_bend(int m);
    return (m == 1) || (sidx[m] == 15);
  endfunction
  function automatic int m_len(int m);
    return dd[m] + 1 + ((m_bend(m) && (acc[m] + kk[m] >= 16)) ? 1 : 0);
  endfunction
  function automatic bit m_err(int m);
    return (m == 1) && (dd[m] == 0);
  endfunction
  function automatic bit m_samp(int m);
    return !m_err(m) && (pos[m] == m_len(m));
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always begin
    @(posedge clk);
    for (int m = 0; m < 2; m++) begin
      if (!rst_n) begin
        dd[m] = 0; kk[m] = 0; pos[m] = 1; acc[m] = 0; sidx[m] = 0;
      end else if (wr_div || wr_frac) begin
        if (wr_div)  dd[m] = (m == 1) ? int'(wdata[3:0]) : int'(wdata);
        if (wr_frac) kk[m] = int'(wdata[7:4]);
        pos[m] = 1; acc[m] = 0; sidx[m] = 0;
      end else if (!m_err(m)) begin
        if (pos[m] == m_len(m)) begin
          if (m_bend(m)) acc[m] = (acc[m] + kk[m]) % 16;
          sidx[m] = (sidx[m] + 1) % 16;
          pos[m] = 1;
        end else pos[m]++;
      end
    end
    #1;
    if (rst_n && !done) begin
      chk(samp_u == m_samp(0), "R2 serial samp", samp_u, m_samp(0));
      chk(tick_u == (m_samp(0) && m_bend(0)), "R3 serial tick", tick_u, m_samp(0) && m_bend(0));
      chk(samp_i == m_samp(1), "R6 ir samp", samp_i, m_samp(1));
      chk(tick_i == m_samp(1), "R6 ir tick", tick_i, m_samp(1));
      chk(err_i == m_err(1), "R7 ir cfg_err", err_i, m_err(1));
      chk(err_u == 1'b0, "R7 serial cfg_err", err_u, 0);
    end
  end

  task automatic wr_reg(bit d, bit f, logic [7:0] v);
    @(negedge clk);
    wr_div = d; wr_frac = f; wdata = v;
    @(negedge clk);
    wr_div = 1'b0; wr_frac = 1'b0;
  endtask

  task automatic cycles_to(bit use_ir, bit want_tick, output int n);
    n = 0;
    forever begin
      @(posedge clk); #1; n++;
      if (use_ir ? (want_tick ? tick_i : samp_i) : (want_tick ? tick_u : samp_u)) break;
    end
  endtask

  task automatic span16(bit use_ir, output int n);
    int t;
    int cnt = 0;
    n = 0;
    cycles_to(use_ir, 1'b1, t);
    while (cnt < 16) begin
      cycles_to(use_ir, 1'b1, t);
      n += t; cnt++;
    end
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    // R1 reset state
    chk(samp_u == 1'b1 && tick_u == 1'b0, "R1 serial after reset", {samp_u, tick_u}, 2);
    chk(err_i == 1'b1 && samp_i == 1'b0, "R1 ir after reset", {err_i, samp_i}, 2);
    repeat (40) @(posedge clk);

    // R2 first strobe latency after a divisor write of 5
    @(negedge clk); wr_div = 1'b1; wdata = 8'h05;
    @(negedge clk); wr_div = 1'b0;
    n = 1;
    if (!samp_u) begin cycles_to(1'b0, 1'b0, n); n++; end
    chk(n == 6, "R2 first strobe latency", n, 6);
    repeat (200) @(posedge clk);

    // R4 serial dither over sixteen bits: D=2, index 5
    wr_reg(1'b1, 1'b0, 8'h02);
    wr_reg(1'b0, 1'b1, 8'h50);
    span16(1'b0, n);
    chk(n == 16 * 48 + 5, "R4 serial sixteen-bit span", n, 16 * 48 + 5);

    // R5 restart: D=3, index 15, first tick one unstretched bit later
    wr_reg(1'b1, 1'b0, 8'h03);
    @(negedge clk); wr_frac = 1'b1; wdata = 8'hF0;
    @(negedge clk); wr_frac = 1'b0;
    cycles_to(1'b0, 1'b1, n);
    chk(n + 1 == 64, "R5 first tick after restart", n + 1, 64);
    span16(1'b0, n);
    chk(n == 16 * 64 + 15, "R4 serial span index 15", n, 16 * 64 + 15);

    // R6 infrared dither: D=3, index 8
    wr_reg(1'b0, 1'b1, 8'h80);
    span16(1'b1, n);
    chk(n == 16 * 4 + 8, "R6 ir sixteen-period span", n, 16 * 4 + 8);

    // R6 upper divisor bits ignored by infrared variant: 0x13 -> D=3, index 0
    wr_reg(1'b1, 1'b1, 8'h03);
    wr_reg(1'b1, 1'b0, 8'h13);
    span16(1'b1, n);
    chk(n == 64, "R6 ir ignores upper divisor bits", n, 64);

    // R7 zero low nibble: serial runs with D=32, infrared flags
    wr_reg(1'b1, 1'b0, 8'h20);
    @(posedge clk); #1;
    chk(err_i == 1'b1, "R7 ir zero divisor flag", err_i, 1);
    chk(err_u == 1'b0, "R7 serial no flag", err_u, 0);
    repeat (600) @(posedge clk);

    // R7 leaving the illegal state
    wr_reg(1'b1, 1'b0, 8'h01);
    @(posedge clk); #1;
    chk(err_i == 1'b0, "R7 ir flag clears", err_i, 0);
    repeat (100) @(posedge clk);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule